// File: doc/BRIEF.md
# CPU exception entry controller

This block is the exception-entry logic of a system-control coprocessor. Each cycle it may accept one exception request, which is already prioritised upstream. A request carries a kind, a store/load flag, the faulting virtual address, a coprocessor number, and the PC and next PC of the faulting instruction. On the clock edge that accepts the request, the block commits all of its architectural updates:

- the exception-level bit in the status register;
- the cause register, holding the exception code, the delay-slot flag and the coprocessor field;
- the exception PC;
- the bad-address register;
- the shadow-register-set control fields.

In the following cycle it raises `redirect_valid` for one cycle, with the handler address on `redirect_pc`. The pipeline uses that strobe to flush and refetch.

The handler address depends on four things: the bootstrap bit (BEV), the exception-level bit (EXL) as it was before the entry, a special offset for TLB refill, and an interrupt-vector bit (IV) in the cause register. A small software port lets the rest of the core read the six registers and write their writable fields.

Control is a three-state machine:

- **ST_BOOT** is entered on synchronous reset and announces the reset vector.
- **ST_IDLE** means no redirect is pending.
- **ST_TAKEN** means a redirect is being presented.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_ACCEPT | any state | ST_TAKEN | a request is present |
| T_QUIET | any state | ST_IDLE | no request is present |
| T_RESET | any state | ST_BOOT | reset |

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous reset leaves the registers as follows. Status reads 0x6, meaning EXL (bit 0) is 0, BEV (bit 1) is 1 and CU1 (bit 2) is 1. Cause, EPC, bad-address, shadow-control and base all read 0. In the cycle after the reset edge, `redirect_valid` is 1 and `redirect_pc` is 0xBFC00000.
- R2: Any accepted request gives `redirect_valid`=1 in the next cycle. The strobe is 0 in a cycle whose preceding edge saw no request. Back-to-back requests give back-to-back strobes. Every kind except reset sets EXL to 1, whatever its earlier value.
- R3: The cause code field (bits 4:0) is set by the request kind, as listed below.

  | Request kind | Code when load | Code when store |
  |---|---|---|
  | interrupt (kind 0) | 0 | 0 |
  | TLB modified (kind 1) | 1 | 1 |
  | TLB invalid (kind 2) | 2 | 3 |
  | TLB refill (kind 3) | 2 | 3 |
  | address error (kind 4) | 4 | 5 |
  | syscall (kind 5) | 8 | 8 |
  | breakpoint (kind 6) | 9 | 9 |
  | reserved instruction (kind 7) | 0xA | 0xA |
  | coprocessor unusable (kind 8) | 0xB | 0xB |
  | overflow (kind 9) | 0xC | 0xC |
  | trap (kind 10) | 0xD | 0xD |
- R4: When `next_pc` equals `cur_pc`+4, EPC takes `cur_pc` and the delay-slot bit (cause bit 9) is cleared. Otherwise EPC takes `cur_pc`-4 and the delay-slot bit is set.
- R5: The shadow-control register holds three fields: the current set in bits 3:0, the previous set in bits 7:4 and the exception set in bits 11:8. On an entry with both EXL and BEV clear, the previous set takes the current set and the current set takes the exception set. Otherwise the register is unchanged.
- R6: With BEV clear, the handler address is base+0x180. The one exception is a TLB refill taken while EXL was clear, which goes to base+0x000.
- R7: An interrupt goes to base+0x200 when cause IV (bit 8) is 1, and to base+0x180 when IV is 0.
- R8: With BEV set, 0xBFC00200 replaces the base and the same offsets apply. An overflow taken with BEV set goes to exactly 0xBFC00200.
- R9: A reset-kind request (kind 11) redirects to 0xBFC00000 and sets CU1. It changes nothing else.
- R10: The cause coprocessor field (bits 6:5) takes `req_cop` on a coprocessor-unusable entry and is cleared on every other entry.
- R11: Address-error and all TLB kinds write `req_vaddr` into the bad-address register. Other kinds leave it unchanged.
- R12: The software port addresses the registers as follows.

  | Address | Register | Writable part |
  |---|---|---|
  | 0 | status | bits 2:0 |
  | 1 | cause | IV only |
  | 2 | EPC | all bits |
  | 3 | bad address | none |
  | 4 | shadow control | bits 11:0 |
  | 5 | base | bits 31:12 |

  Unwritable bits read 0. A write presented in the same cycle as a request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Exception request present this cycle |
| req_kind | input | 4 | Exception kind (encoding in R3, 11 = reset) |
| req_store | input | 1 | Faulting access was a store |
| req_vaddr | input | 32 | Faulting virtual address |
| req_cop | input | CE_W | Coprocessor number for the coprocessor-unusable kind |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | Next PC at the time of the fault |
| sw_we | input | 1 | Software register write strobe |
| sw_waddr | input | 3 | Software write register select |
| sw_wdata | input | 32 | Software write data |
| sw_raddr | input | 3 | Software read register select |
| sw_rdata | output | 32 | Read data, combinational from `sw_raddr` |
| redirect_valid | output | 1 | One-cycle strobe announcing a handler fetch |
| redirect_pc | output | 32 | Handler address |

## Verification
The bench builds the block with the default SET_W=4 and CE_W=2. At those values all three shadow-set fields and the coprocessor field fit the layout given in R5 and R10, so the bench can drive nonzero set numbers and coprocessor numbers and read them back exactly. A behavioural model predicts the redirect on every clock and the contents of every register after each operation. The stimulus deliberately flips BEV, EXL and IV between requests, so that each vector branch and each shadow-set hold-or-swap case is reached.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [3:0] {
        EK_INTR       = 4'd0,
        EK_TLB_MOD    = 4'd1,
        EK_TLB_INV    = 4'd2,
        EK_TLB_REFILL = 4'd3,
        EK_ADDR_ERR   = 4'd4,
        EK_SYSCALL    = 4'd5,
        EK_BREAK      = 4'd6,
        EK_RESV       = 4'd7,
        EK_COP_UNUSE  = 4'd8,
        EK_OVERFLOW   = 4'd9,
        EK_TRAP       = 4'd10,
        EK_RESET      = 4'd11
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_TAKEN = 2'd2
    } ctl_state_e;

    localparam int          AW        = 32;
    localparam logic [31:0] RESET_VEC = 32'hBFC0_0000;
    localparam logic [31:0] BOOT_BASE = 32'hBFC0_0200;
    localparam logic [31:0] OFS_GEN   = 32'h0000_0180;
    localparam logic [31:0] OFS_INTV  = 32'h0000_0200;
    localparam logic [31:0] INSN_B    = 32'd4;

    localparam logic [2:0] RSEL_STATUS = 3'd0;
    localparam logic [2:0] RSEL_CAUSE  = 3'd1;
    localparam logic [2:0] RSEL_EPC    = 3'd2;
    localparam logic [2:0] RSEL_BADV   = 3'd3;
    localparam logic [2:0] RSEL_SRS    = 3'd4;
    localparam logic [2:0] RSEL_EBASE  = 3'd5;

    localparam int ST_EXL    = 0;
    localparam int ST_BEV    = 1;
    localparam int ST_CU1    = 2;
    localparam int CA_CE_LSB = 5;
    localparam int CA_IV     = 8;
    localparam int CA_BD     = 9;
    localparam int BASE_LSB  = 12;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
    import exc_entry_pkg::*;
(
    input  exc_kind_e   kind,
    input  logic        store,
    output logic [4:0]  code,
    output logic        addr_capture,
    output logic        cop_capture
);
    always_comb begin
        code         = 5'd0;
        addr_capture = 1'b0;
        cop_capture  = 1'b0;
        case (kind)
            EK_INTR:       code = 5'd0;
            EK_TLB_MOD:    begin code = 5'd1; addr_capture = 1'b1; end
            EK_TLB_INV,
            EK_TLB_REFILL: begin code = store ? 5'd3 : 5'd2; addr_capture = 1'b1; end
            EK_ADDR_ERR:   begin code = store ? 5'd5 : 5'd4; addr_capture = 1'b1; end
            EK_SYSCALL:    code = 5'd8;
            EK_BREAK:      code = 5'd9;
            EK_RESV:       code = 5'hA;
            EK_COP_UNUSE:  begin code = 5'hB; cop_capture = 1'b1; end
            EK_OVERFLOW:   code = 5'hC;
            EK_TRAP:       code = 5'hD;
            default:       code = 5'd0;
        endcase
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
(
    input  exc_kind_e        kind,
    input  logic             exl_old,
    input  logic             bev,
    input  logic             iv,
    input  logic [AW-1:0]    ebase,
    output logic [AW-1:0]    vec
);
    logic [AW-1:0] base;
    logic [AW-1:0] ofs;

    always_comb begin
        base = bev ? BOOT_BASE : ebase;
        if (kind == EK_TLB_REFILL && !exl_old) begin
            ofs = '0;
        end else if (kind == EK_INTR && iv) begin
            ofs = OFS_INTV;
        end else begin
            ofs = OFS_GEN;
        end

        if (kind == EK_RESET) begin
            vec = RESET_VEC;
        end else if (kind == EK_OVERFLOW && bev) begin
            vec = BOOT_BASE;
        end else begin
            vec = base + ofs;
        end
    end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_entry_pkg::*;
(
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] npc,
    output logic [AW-1:0] epc,
    output logic          in_slot
);
    always_comb begin
        in_slot = (npc != pc + INSN_B);
        epc     = in_slot ? (pc - INSN_B) : pc;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int CE_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              req_store,
    input  logic [31:0]       req_vaddr,
    input  logic [CE_W-1:0]   req_cop,
    input  logic [31:0]       cur_pc,
    input  logic [31:0]       next_pc,
    input  logic              sw_we,
    input  logic [2:0]        sw_waddr,
    input  logic [31:0]       sw_wdata,
    input  logic [2:0]        sw_raddr,
    output logic [31:0]       sw_rdata,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);
    localparam int SRS_BITS  = 3 * SET_W;
    localparam int BASE_BITS = AW - BASE_LSB;

    ctl_state_e state_q, state_d;

    logic                  exl_q, bev_q, cu1_q;
    logic [4:0]            code_q;
    logic [CE_W-1:0]       ce_q;
    logic                  iv_q, bd_q;
    logic [AW-1:0]         epc_q, badv_q, rpc_q;
    logic [SET_W-1:0]      cur_q, prev_q, ess_q;
    logic [BASE_BITS-1:0]  base_q;

    exc_kind_e     kind;
    logic [4:0]    map_code;
    logic          map_addr, map_cop;
    logic [AW-1:0] vec, calc_epc, ebase_full;
    logic          calc_slot;
    logic          entry_normal, entry_reset;
    logic          unused_wdata;

    assign kind         = exc_kind_e'(req_kind);
    assign ebase_full   = {base_q, {BASE_LSB{1'b0}}};
    assign entry_reset  = req_valid && (kind == EK_RESET);
    assign entry_normal = req_valid && (kind != EK_RESET);
    assign unused_wdata = ^sw_wdata;

    exc_code_map u_code (
        .kind         (kind),
        .store        (req_store),
        .code         (map_code),
        .addr_capture (map_addr),
        .cop_capture  (map_cop)
    );

    exc_vector_sel u_vec (
        .kind    (kind),
        .exl_old (exl_q),
        .bev     (bev_q),
        .iv      (iv_q),
        .ebase   (ebase_full),
        .vec     (vec)
    );

    exc_epc_calc u_epc (
        .pc      (cur_pc),
        .npc     (next_pc),
        .epc     (calc_epc),
        .in_slot (calc_slot)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = req_valid ? ST_TAKEN : ST_IDLE;
            ST_IDLE:  state_d = req_valid ? ST_TAKEN : ST_IDLE;
            ST_TAKEN: state_d = req_valid ? ST_TAKEN : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        redirect_valid = 1'b0;
        unique case (state_q)
            ST_BOOT:  redirect_valid = 1'b1;
            ST_IDLE:  redirect_valid = 1'b0;
            ST_TAKEN: redirect_valid = 1'b1;
            default:  redirect_valid = 1'b0;
        endcase
        redirect_pc = rpc_q;
    end

    // architectural register commit
    always_ff @(posedge clk) begin
        if (rst) begin
            exl_q  <= 1'b0;
            bev_q  <= 1'b1;
            cu1_q  <= 1'b1;
            code_q <= '0;
            ce_q   <= '0;
            iv_q   <= 1'b0;
            bd_q   <= 1'b0;
            epc_q  <= '0;
            badv_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
            ess_q  <= '0;
            base_q <= '0;
            rpc_q  <= RESET_VEC;
        end else if (req_valid) begin
            rpc_q <= vec;
            if (entry_reset) begin
                cu1_q <= 1'b1;
            end
            if (entry_normal) begin
                exl_q  <= 1'b1;
                epc_q  <= calc_epc;
                bd_q   <= calc_slot;
                code_q <= map_code;
                ce_q   <= map_cop ? req_cop : '0;
                if (map_addr) begin
                    badv_q <= req_vaddr;
                end
                if (!exl_q && !bev_q) begin
                    prev_q <= cur_q;
                    cur_q  <= ess_q;
                end
            end
        end else if (sw_we) begin
            case (sw_waddr)
                RSEL_STATUS: begin
                    exl_q <= sw_wdata[ST_EXL];
                    bev_q <= sw_wdata[ST_BEV];
                    cu1_q <= sw_wdata[ST_CU1];
                end
                RSEL_CAUSE: iv_q  <= sw_wdata[CA_IV];
                RSEL_EPC:   epc_q <= sw_wdata;
                RSEL_SRS: begin
                    cur_q  <= sw_wdata[0 +: SET_W];
                    prev_q <= sw_wdata[SET_W +: SET_W];
                    ess_q  <= sw_wdata[2*SET_W +: SET_W];
                end
                RSEL_EBASE: base_q <= sw_wdata[AW-1:BASE_LSB];
                default: ;
            endcase
        end
    end

    // software read
    logic [31:0] status_w, cause_w, srs_w;
    always_comb begin
        status_w         = '0;
        status_w[ST_EXL] = exl_q;
        status_w[ST_BEV] = bev_q;
        status_w[ST_CU1] = cu1_q;

        cause_w                     = '0;
        cause_w[4:0]                = code_q;
        cause_w[CA_CE_LSB +: CE_W]  = ce_q;
        cause_w[CA_IV]              = iv_q;
        cause_w[CA_BD]              = bd_q;

        srs_w                       = '0;
        srs_w[0 +: SET_W]           = cur_q;
        srs_w[SET_W +: SET_W]       = prev_q;
        srs_w[2*SET_W +: SET_W]     = ess_q;

        case (sw_raddr)
            RSEL_STATUS: sw_rdata = status_w;
            RSEL_CAUSE:  sw_rdata = cause_w;
            RSEL_EPC:    sw_rdata = epc_q;
            RSEL_BADV:   sw_rdata = badv_q;
            RSEL_SRS:    sw_rdata = srs_w;
            RSEL_EBASE:  sw_rdata = ebase_full;
            default:     sw_rdata = '0;
        endcase
    end

    logic unused_srs_width;
    assign unused_srs_width = (SRS_BITS > 32);

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
    parameter int SET_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        req_kind,
    input logic [31:0]       cur_pc,
    input logic [31:0]       next_pc,
    input logic              redirect_valid,
    input logic [31:0]       redirect_pc,
    input logic              exl,
    input logic              bev,
    input logic              bd,
    input logic [31:0]       epc,
    input logic [SET_W-1:0]  srs_cur,
    input logic [SET_W-1:0]  srs_prev,
    input logic [SET_W-1:0]  srs_ess
);
    // R2
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> redirect_valid);
    // R2
    a_r2_strobe_drops: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !redirect_valid);
    // R2
    a_r2_exl_set: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 4'd11) |=> exl);
    // R4
    a_r4_epc_seq: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 4'd11 && next_pc == cur_pc + 32'd4)
        |=> (epc == $past(cur_pc) && !bd));
    // R5
    a_r5_srs_swap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 4'd11 && !exl && !bev)
        |=> (srs_cur == $past(srs_ess) && srs_prev == $past(srs_cur)));
    // R5
    a_r5_srs_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (exl || bev)) |=> ($stable(srs_cur) && $stable(srs_prev)));
    // R9
    a_r9_reset_vec: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 4'd11) |=> (redirect_pc == 32'hBFC0_0000));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.SET_W(SET_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .cur_pc         (cur_pc),
    .next_pc        (next_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .exl            (exl_q),
    .bev            (bev_q),
    .bd             (bd_q),
    .epc            (epc_q),
    .srs_cur        (cur_q),
    .srs_prev       (prev_q),
    .srs_ess        (ess_q)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_cop = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] next_pc = 32'd4;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_waddr = '0;
    logic [31:0] sw_wdata = '0;
    logic [2:0]  sw_raddr = '0;
    logic [31:0] sw_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    exc_entry_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_store(req_store), .req_vaddr(req_vaddr), .req_cop(req_cop),
        .cur_pc(cur_pc), .next_pc(next_pc), .sw_we(sw_we), .sw_waddr(sw_waddr),
        .sw_wdata(sw_wdata), .sw_raddr(sw_raddr), .sw_rdata(sw_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic        m_exl, m_bev, m_cu1, m_iv, m_bd, m_rv;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [31:0] m_epc, m_badv, m_ebase, m_rpc;
    logic [3:0]  m_cur, m_prev, m_ess;

    function automatic logic [4:0] ref_code(input int k, input logic st);
        case (k)
            1: return 5'd1;
            2, 3: return st ? 5'd3 : 5'd2;
            4: return st ? 5'd5 : 5'd4;
            5: return 5'd8;
            6: return 5'd9;
            7: return 5'd10;
            8: return 5'd11;
            9: return 5'd12;
            10: return 5'd13;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_vec(input int k);
        logic [31:0] base;
        logic [31:0] off;
        if (k == 11) return 32'hBFC0_0000;
        if (k == 9 && m_bev) return 32'hBFC0_0200;
        base = m_bev ? 32'hBFC0_0200 : m_ebase;
        if (k == 3 && !m_exl) off = 0;
        else if (k == 0 && m_iv) off = 32'h200;
        else off = 32'h180;
        return base + off;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_cu1, m_bev, m_exl};
            3'd1: return {22'd0, m_bd, m_iv, 1'b0, m_ce, m_code};
            3'd2: return m_epc;
            3'd3: return m_badv;
            3'd4: return {20'd0, m_ess, m_prev, m_cur};
            3'd5: return m_ebase;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_exl = 0; m_bev = 1; m_cu1 = 1; m_iv = 0; m_bd = 0;
            m_code = 0; m_ce = 0; m_epc = 0; m_badv = 0; m_ebase = 0;
            m_cur = 0; m_prev = 0; m_ess = 0;
            m_rv = 1; m_rpc = 32'hBFC0_0000;
        end else if (req_valid) begin
            int k;
            k = int'(req_kind);
            m_rv  = 1;
            m_rpc = ref_vec(k);
            if (k == 11) begin
                m_cu1 = 1;
            end else begin
                if (!m_exl && !m_bev) begin
                    m_prev = m_cur;
                    m_cur  = m_ess;
                end
                m_exl  = 1;
                m_code = ref_code(k, req_store);
                m_ce   = (k == 8) ? req_cop : 2'd0;
                if (k >= 1 && k <= 4) m_badv = req_vaddr;
                if (next_pc == cur_pc + 4) begin
                    m_epc = cur_pc; m_bd = 0;
                end else begin
                    m_epc = cur_pc - 4; m_bd = 1;
                end
            end
        end else begin
            m_rv = 0;
            if (sw_we) begin
                case (sw_waddr)
                    3'd0: begin m_exl = sw_wdata[0]; m_bev = sw_wdata[1]; m_cu1 = sw_wdata[2]; end
                    3'd1: m_iv = sw_wdata[8];
                    3'd2: m_epc = sw_wdata;
                    3'd4: begin m_cur = sw_wdata[3:0]; m_prev = sw_wdata[7:4]; m_ess = sw_wdata[11:8]; end
                    3'd5: m_ebase = sw_wdata & 32'hFFFF_F000;
                    default: ;
                endcase
            end
        end
    end

    // per-clock redirect comparison
    always @(negedge clk) begin
        if (!done && total >= 0) begin
            total++;
            if (redirect_valid !== m_rv) begin
                bad++;
                $display("FAIL %s redirect_valid actual=%0b expected=%0b", cur_tag, redirect_valid, m_rv);
            end
            if (m_rv) begin
                total++;
                if (redirect_pc !== m_rpc) begin
                    bad++;
                    $display("FAIL %s redirect_pc actual=%h expected=%h", cur_tag, redirect_pc, m_rpc);
                end
            end
        end
    end

    task automatic chk_reg(input logic [2:0] a);
        sw_raddr = a;
        #1;
        total++;
        if (sw_rdata !== m_read(a)) begin
            bad++;
            $display("FAIL %s reg%0d actual=%h expected=%h", cur_tag, a, sw_rdata, m_read(a));
        end
    endtask

    task automatic chk_all();
        for (int a = 0; a < 6; a++) chk_reg(3'(a));
    endtask

    task automatic exc(input int k, input logic st, input logic [31:0] va,
                       input logic [1:0] cop, input logic [31:0] pc,
                       input logic [31:0] npc, input bit keep);
        @(negedge clk);
        req_valid = 1; req_kind = 4'(k); req_store = st; req_vaddr = va;
        req_cop = cop; cur_pc = pc; next_pc = npc;
        @(negedge clk);
        if (!keep) req_valid = 0;
        chk_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1; sw_waddr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 0;
        chk_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        @(negedge clk); @(negedge clk);
        rst = 0;
        chk_all();                       // R1 reset state, boot redirect compared per clock
        @(negedge clk); chk_all();       // R2 strobe falls without request

        cur_tag = "R8";                  // BEV set after reset: base 0xBFC00200
        exc(5, 0, 0, 0, 32'h100, 32'h104, 0);
        cur_tag = "R12";
        wr(3'd0, 32'h0000_0004);         // clear EXL and BEV
        wr(3'd5, 32'h8000_0ABC);         // base, low bits dropped
        wr(3'd4, 32'h0000_0502);         // ess=5 cur=2
        wr(3'd3, 32'hDEAD_BEEF);         // read-only, ignored
        cur_tag = "R5";
        exc(5, 0, 0, 0, 32'h200, 32'h204, 0);   // R4 R6 swap
        cur_tag = "R6";
        exc(3, 0, 32'h1111_0000, 0, 32'h300, 32'h304, 0); // EXL set -> +0x180, R11
        wr(3'd0, 32'h0000_0004);
        exc(3, 1, 32'h2222_0000, 0, 32'h310, 32'h314, 0); // EXL clear -> +0
        cur_tag = "R4";
        wr(3'd0, 32'h0000_0004);
        exc(4, 1, 32'h3333_0004, 0, 32'h400, 32'h408, 0); // delay slot, R11
        cur_tag = "R11";
        exc(6, 0, 32'h4444_0000, 0, 32'h500, 32'h504, 0); // bad address unchanged
        cur_tag = "R7";
        wr(3'd1, 32'h0000_0100);
        exc(0, 0, 0, 0, 32'h600, 32'h604, 0);
        wr(3'd1, 32'h0000_0000);
        exc(0, 0, 0, 0, 32'h610, 32'h618, 0);
        cur_tag = "R10";
        exc(8, 0, 0, 2'd2, 32'h700, 32'h704, 0);
        exc(10, 0, 0, 2'd3, 32'h710, 32'h714, 0);
        cur_tag = "R3";
        exc(1, 1, 32'h5555_0000, 0, 32'h800, 32'h804, 0);
        exc(2, 0, 32'h5555_1000, 0, 32'h810, 32'h814, 0);
        exc(2, 1, 32'h5555_2000, 0, 32'h820, 32'h824, 0);
        exc(4, 0, 32'h5555_3000, 0, 32'h830, 32'h834, 0);
        exc(7, 0, 0, 0, 32'h840, 32'h844, 0);
        exc(9, 0, 0, 0, 32'h850, 32'h854, 0);
        cur_tag = "R12";                 // write during request is ignored
        @(negedge clk);
        req_valid = 1; req_kind = 4'd5; cur_pc = 32'h900; next_pc = 32'h904;
        sw_we = 1; sw_waddr = 3'd2; sw_wdata = 32'h1234_5678;
        @(negedge clk);
        req_valid = 0; sw_we = 0;
        chk_all();
        cur_tag = "R8";
        wr(3'd0, 32'h0000_0002);         // BEV=1, EXL=0, CU1=0
        exc(9, 0, 0, 0, 32'hA00, 32'hA04, 0);
        wr(3'd0, 32'h0000_0002);
        exc(3, 0, 32'h6666_0000, 0, 32'hA10, 32'hA14, 0);
        exc(6, 0, 0, 0, 32'hA20, 32'hA24, 0);
        cur_tag = "R9";
        wr(3'd0, 32'h0000_0000);
        exc(11, 0, 32'h7777_0000, 0, 32'hB00, 32'hB08, 0);
        cur_tag = "R2";
        exc(5, 0, 0, 0, 32'hC00, 32'hC04, 1);
        exc(6, 0, 0, 0, 32'hC04, 32'hC08, 0);
        @(negedge clk); chk_all();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule